// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Sequencer

This block decides when a small 8-bit CPU core stops its program to serve an interrupt, and which one it serves. Request lines from the maskable sources are pulses. Each pulse is caught in a pending latch. The latch holds the request until the block accepts that source, so a request that arrives while interrupts are disabled is not lost. A software trap request has its own latch. The trap is accepted even while the global disable flag is set.

An entry begins only when the core reports an instruction boundary. The entry is a short sequence with a fixed timing. First comes a one-cycle register-save request, together with an acknowledge that carries the chosen index. Next comes a one-cycle vector strobe, and the global disable flag is set in that same cycle. A return strobe from the core produces a one-cycle restore request and clears the disable flag. The block also gives two wake indications. One is for a light sleep state and the other for a deep stop state. A parameter selects which sources may end a deep stop.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the global disable flag `mask_o` is 1, no request is pending, and `save_req`, `vec_valid`, `restore_req`, `wake_light` and `wake_deep` are all 0.
- R2: A pulse on `irq_req[i]` sets a pending latch for source i. While `mask_o` is 1 the source is not accepted. Once `mask_clr` clears the flag, the source is accepted.
- R3: An entry is accepted only on a clock edge where `insn_done` is 1. While `insn_done` stays 0, no `save_req` appears.
- R4: An entry accepted at edge k gives `save_req`=1 and `ack_valid`=1 for the one cycle after k, with `ack_idx` equal to the chosen index. In the following cycle `vec_valid`=1, `vec_idx` holds the same index, and `mask_o` is 1.
- R5: While `mask_o` is 1 after an entry, no further maskable source is accepted, even if requests are pending.
- R6: When several maskable sources are pending, the lowest index is accepted first. The other sources stay pending and are served in index order after later returns.
- R7: A trap request is accepted even when `mask_o` is 1. The trap outranks every maskable source and is reported with index N_SRC (8 by default).
- R8: An `iret` pulse in an idle cycle gives `restore_req`=1 for exactly the next cycle, and `mask_o`=0 from that cycle on.
- R9: `wake_light` is 1 while any request is pending. `wake_deep` is 1 only while a source enabled in HALT_WAKE is pending. The default value of HALT_WAKE enables sources 0 and 1.
- R10: Acceptance clears the chosen source's pending latch. However, if that source's request is high on the acceptance edge, the latch stays set and the source is served again after the return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | N_SRC | Request pulses from maskable sources, index 0 highest |
| trap_req | input | 1 | Software trap request pulse |
| insn_done | input | 1 | Current instruction completes at this edge |
| mask_set | input | 1 | Core sets the global disable flag |
| mask_clr | input | 1 | Core clears the global disable flag |
| iret | input | 1 | Return-from-handler strobe |
| save_req | output | 1 | Save the PC, X, A and condition codes |
| restore_req | output | 1 | Restore the saved registers |
| vec_valid | output | 1 | Load the vector selected by `vec_idx` |
| vec_idx | output | VW | Index of the source being entered |
| ack_valid | output | 1 | One-cycle acknowledge to the chosen source |
| ack_idx | output | VW | Index being acknowledged |
| mask_o | output | 1 | Global disable flag |
| wake_light | output | 1 | Wake from light sleep |
| wake_deep | output | 1 | Wake from deep stop |

## Verification
A request pulse is latched at the edge that samples it. The latch can be accepted at the next edge, if `insn_done` is high there and the flag is clear. `save_req` then shows in the cycle after that edge, and `vec_valid` with the flag set follows one cycle later. `restore_req` and the cleared flag appear in the cycle after the edge that samples `iret`. The bench drives inputs and samples outputs on the falling clock edge. It steps exactly that number of half-period pairs before each comparison, so every expected value is read in the first cycle it is due. It also reads the cycle just before, to show the value did not appear early.

// File: rtl/irq_vec_pkg.sv
// Shared types for the interrupt sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package irq_vec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SAVE = 2'd1,
        ST_LOAD = 2'd2
    } seq_state_t;
endpackage

// File: rtl/irq_pend_latch.sv
// Pending latches, one per request line (the trap included).
// A high set input raises the latch. An acceptance clears only the chosen
// bit, and a set in the same cycle wins over that clear.
// Assumes: clr_idx is below W whenever clr_vld is high.
module irq_pend_latch #(
    parameter int W  = 9,
    parameter int VW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  set_i,
    input  logic          clr_vld,
    input  logic [VW-1:0] clr_idx,
    output logic [W-1:0]  pend_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Hold one request until its own acceptance.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_o[i] <= 1'b0;
            else if (set_i[i])
                pend_o[i] <= 1'b1;
            else if (clr_vld && (clr_idx == VW'(i)))
                pend_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_prio_sel.sv
// Fixed priority selector. Bit N_SRC of the input is the trap, which is
// never gated by the flag and beats all others. Among the remaining bits
// the lowest index wins, and only while the flag is clear.
// Assumes: purely combinational; pend and mask come from registers.
module irq_prio_sel #(
    parameter int N_SRC = 8,
    parameter int VW    = 4
) (
    input  logic [N_SRC:0]  pend,
    input  logic            mask,
    output logic            sel_vld,
    output logic [VW-1:0]   sel_idx
);
    logic [N_SRC-1:0] eligible;

    // Gate the maskable requests by the global flag.
    always_comb eligible = pend[N_SRC-1:0] & {N_SRC{~mask}};

    // Pick the trap, else the lowest eligible index.
    always_comb begin
        sel_vld = 1'b0;
        sel_idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                sel_vld = 1'b1;
                sel_idx = VW'(i);
            end
        end
        if (pend[N_SRC]) begin
            sel_vld = 1'b1;
            sel_idx = VW'(N_SRC);
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
// Entry and return sequencer with the global disable flag.
// IDLE -> SAVE (save request and acknowledge) -> LOAD (vector, flag set).
// A return is accepted only in IDLE, and it wins over a new entry in the
// same cycle.
// Assumes: the core raises iret only at the end of a handler.
module irq_entry_seq #(
    parameter int VW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          insn_done,
    input  logic          iret,
    input  logic          mask_set,
    input  logic          mask_clr,
    input  logic          sel_vld,
    input  logic [VW-1:0] sel_idx,
    output logic          take,
    output logic          save_req,
    output logic          vec_valid,
    output logic          restore_req,
    output logic [VW-1:0] cur_idx,
    output logic          mask_o
);
    import irq_vec_pkg::*;

    seq_state_t state, state_nx;
    logic       ret_ok;

    // Decide acceptance of a return or of a new entry.
    always_comb begin
        ret_ok = (state == ST_IDLE) && iret;
        take   = (state == ST_IDLE) && !iret && insn_done && sel_vld;
    end

    // Next-state selection for the entry sequence.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (take) state_nx = ST_SAVE;
            ST_SAVE: state_nx = ST_LOAD;
            ST_LOAD: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register, captured index and return pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cur_idx     <= '0;
            restore_req <= 1'b0;
        end else begin
            state       <= state_nx;
            restore_req <= ret_ok;
            if (take)
                cur_idx <= sel_idx;
        end
    end

    // Global disable flag: entry sets it, then return, clear, set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_o <= 1'b1;
        else if (state == ST_SAVE)
            mask_o <= 1'b1;
        else if (ret_ok || mask_clr)
            mask_o <= 1'b0;
        else if (mask_set)
            mask_o <= 1'b1;
    end

    // Decode the sequence strobes from the state.
    always_comb begin
        save_req  = (state == ST_SAVE);
        vec_valid = (state == ST_LOAD);
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
// Top level: pending latches, priority selector, entry sequencer and wake
// logic. Bit N_SRC of the internal pending vector is the trap.
// Assumes: request lines are synchronous to clk.
module irq_vec_ctrl #(
    parameter int                N_SRC     = 8,
    parameter logic [N_SRC-1:0]  HALT_WAKE = 8'b0000_0011,
    parameter int                VW        = $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_req,
    input  logic             trap_req,
    input  logic             insn_done,
    input  logic             mask_set,
    input  logic             mask_clr,
    input  logic             iret,
    output logic             save_req,
    output logic             restore_req,
    output logic             vec_valid,
    output logic [VW-1:0]    vec_idx,
    output logic             ack_valid,
    output logic [VW-1:0]    ack_idx,
    output logic             mask_o,
    output logic             wake_light,
    output logic             wake_deep
);
    localparam int NW = N_SRC + 1;

    logic [NW-1:0] pend;
    logic          sel_vld;
    logic [VW-1:0] sel_idx;
    logic          take;
    logic [VW-1:0] cur_idx;

    irq_pend_latch #(.W(NW), .VW(VW)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   ({trap_req, irq_req}),
        .clr_vld (take),
        .clr_idx (sel_idx),
        .pend_o  (pend)
    );

    irq_prio_sel #(.N_SRC(N_SRC), .VW(VW)) u_sel (
        .pend    (pend),
        .mask    (mask_o),
        .sel_vld (sel_vld),
        .sel_idx (sel_idx)
    );

    irq_entry_seq #(.VW(VW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .insn_done   (insn_done),
        .iret        (iret),
        .mask_set    (mask_set),
        .mask_clr    (mask_clr),
        .sel_vld     (sel_vld),
        .sel_idx     (sel_idx),
        .take        (take),
        .save_req    (save_req),
        .vec_valid   (vec_valid),
        .restore_req (restore_req),
        .cur_idx     (cur_idx),
        .mask_o      (mask_o)
    );

    // Drive the acknowledge and the vector from the captured index.
    always_comb begin
        ack_valid = save_req;
        ack_idx   = cur_idx;
        vec_idx   = cur_idx;
    end

    // Wake rules: any pending request, or a deep-stop-capable one.
    always_comb begin
        wake_light = |pend;
        wake_deep  = |(pend[N_SRC-1:0] & HALT_WAKE);
    end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
// Protocol checker for irq_vec_ctrl, attached by bind.
// Assumes: a synchronous active-low reset on rst_n.
module irq_vec_ctrl_chk #(
    parameter int N_SRC = 8,
    parameter int VW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          insn_done,
    input logic          save_req,
    input logic          vec_valid,
    input logic          restore_req,
    input logic          ack_valid,
    input logic [VW-1:0] ack_idx,
    input logic [VW-1:0] vec_idx,
    input logic          mask_o,
    input logic          wake_light,
    input logic          wake_deep
);
    a_r3_entry_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(save_req) |-> $past(insn_done));

    a_r4_vector_follows_save: assert property (@(posedge clk) disable iff (!rst_n)
        save_req |=> (vec_valid && mask_o && !save_req && vec_idx == $past(ack_idx)));

    a_r4_ack_with_save: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid == save_req);

    a_r5_maskable_only_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(save_req) && ack_idx != VW'(N_SRC)) |-> !$past(mask_o));

    a_r8_restore_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        restore_req |-> !mask_o);

    a_r9_deep_implies_light: assert property (@(posedge clk) disable iff (!rst_n)
        wake_deep |-> wake_light);

    a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({save_req, vec_valid, restore_req}));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.N_SRC(N_SRC), .VW(VW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .insn_done   (insn_done),
    .save_req    (save_req),
    .vec_valid   (vec_valid),
    .restore_req (restore_req),
    .ack_valid   (ack_valid),
    .ack_idx     (ack_idx),
    .vec_idx     (vec_idx),
    .mask_o      (mask_o),
    .wake_light  (wake_light),
    .wake_deep   (wake_deep)
);

// File: tb/irq_vec_ctrl_tb_top.sv
module irq_vec_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_SRC      = 8;
    localparam int VW         = 4;
    localparam int TRAP_IDX   = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [N_SRC-1:0] irq_req;
    logic             trap_req, insn_done, mask_set, mask_clr, iret;
    logic             save_req, restore_req, vec_valid, ack_valid, mask_o;
    logic             wake_light, wake_deep;
    logic [VW-1:0]    vec_idx, ack_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_vec_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .trap_req(trap_req),
        .insn_done(insn_done), .mask_set(mask_set), .mask_clr(mask_clr),
        .iret(iret), .save_req(save_req), .restore_req(restore_req),
        .vec_valid(vec_valid), .vec_idx(vec_idx), .ack_valid(ack_valid),
        .ack_idx(ack_idx), .mask_o(mask_o), .wake_light(wake_light),
        .wake_deep(wake_deep)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_req = '0; trap_req = 1'b0; insn_done = 1'b1;
        mask_set = 1'b0; mask_clr = 1'b0; iret = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic pulse_src(input int i);
        irq_req[i] = 1'b1; tick(); irq_req[i] = 1'b0;
    endtask

    task automatic unmask();
        mask_clr = 1'b1; tick(); mask_clr = 1'b0;
    endtask

    // Expect save now, vector on the next cycle.
    task automatic expect_entry(input string req, input int idx);
        check(save_req && ack_valid, req, save_req, 1);
        check(ack_idx == VW'(idx), req, ack_idx, idx);
        tick();
        check(vec_valid && mask_o, req, {vec_valid, mask_o}, 3);
        check(vec_idx == VW'(idx), req, vec_idx, idx);
        tick();
    endtask

    task automatic do_return(input string req);
        iret = 1'b1; tick(); iret = 1'b0;
        check(restore_req && !mask_o, req, {restore_req, mask_o}, 2);
    endtask

    task automatic t_reset();
        do_reset();
        check(mask_o == 1'b1, "R1", mask_o, 1);
        check(!save_req && !vec_valid && !restore_req, "R1", {save_req, vec_valid, restore_req}, 0);
        check(!wake_light && !wake_deep, "R1", {wake_light, wake_deep}, 0);
    endtask

    task automatic t_masked_latch();
        do_reset();
        pulse_src(3);
        for (int k = 0; k < 3; k++) begin
            check(!save_req, "R2", save_req, 0); tick();
        end
        unmask();
        check(!mask_o && !save_req, "R2", {mask_o, save_req}, 0);
        tick();
        expect_entry("R2", 3);
        do_return("R8");
        tick();
        check(!restore_req, "R8", restore_req, 0);
    endtask

    task automatic t_boundary();
        do_reset();
        unmask();
        insn_done = 1'b0;
        pulse_src(5);
        for (int k = 0; k < 4; k++) begin
            check(!save_req, "R3", save_req, 0); tick();
        end
        insn_done = 1'b1;
        tick();
        expect_entry("R3", 5);
    endtask

    task automatic t_priority();
        do_reset();
        unmask();
        insn_done = 1'b0;
        irq_req = 8'b0101_0100; tick(); irq_req = '0;
        insn_done = 1'b1;
        tick();
        expect_entry("R6", 2);
        for (int k = 0; k < 3; k++) begin
            check(!save_req && wake_light, "R5", {save_req, wake_light}, 1); tick();
        end
        do_return("R8");
        tick(); expect_entry("R6", 4);
        do_return("R8");
        tick(); expect_entry("R6", 6);
        do_return("R8");
        tick();
        check(!wake_light && !save_req, "R10", {wake_light, save_req}, 0);
    endtask

    task automatic t_trap();
        do_reset();
        insn_done = 1'b0;
        irq_req[1] = 1'b1; trap_req = 1'b1; tick();
        irq_req[1] = 1'b0; trap_req = 1'b0;
        insn_done = 1'b1;
        tick();
        expect_entry("R7", TRAP_IDX);
        check(!save_req, "R7", save_req, 0);
        do_return("R8");
        tick();
        expect_entry("R7", 1);
    endtask

    task automatic t_wake();
        do_reset();
        pulse_src(5);
        check(wake_light && !wake_deep, "R9", {wake_light, wake_deep}, 2);
        pulse_src(1);
        check(wake_light && wake_deep, "R9", {wake_light, wake_deep}, 3);
    endtask

    task automatic t_set_wins();
        do_reset();
        irq_req[0] = 1'b1; mask_clr = 1'b1; tick(); mask_clr = 1'b0;
        tick();
        irq_req[0] = 1'b0;
        expect_entry("R10", 0);
        do_return("R10");
        tick();
        expect_entry("R10", 0);
        do_return("R10");
        tick(); tick();
        check(!save_req && !wake_light, "R10", {save_req, wake_light}, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_masked_latch();
        t_boundary();
        t_priority();
        t_trap();
        t_wake();
        t_set_wins();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end
endmodule